// File: doc/BRIEF.md
# Sync-gated TTL video pixel sampler

This block watches an 8-bit parallel digital video port and takes samples of it at a fixed spacing, set by a programmable per-pixel cycle count. Each sample holds the line sync, the frame sync and two bits each of red, green and blue. Four samples in a row are packed into one 32-bit word, and that word is offered to a downstream FIFO through a single-cycle write strobe. The FIFO never stalls the sampler. When the FIFO reports full, the word is lost and the pixel timing carries on as if the word had been written.

Line sync is checked at the boundary between two words. If line sync is high there, the block stops taking samples and sends all-zero words at a slow fixed cadence, which mark the line break in the stream. When line sync drops, the block waits a fixed alignment offset and then takes the first pixel of the new line. Every line therefore starts at the same phase relative to the sync edge. The per-pixel setting is captured only at that line start.

Top module: `ttl_video_sampler`

## Requirements
- R1: While reset is high and on the first cycle after it, the write strobe is 0 and the data output is zero. Reset puts the block in the sync-wait state.
- R2: Each sample is the 8-bit port value, unchanged. Bit 7 is line sync (active high), bit 6 is frame sync, bits 5:4 are red, bits 3:2 are green and bits 1:0 are blue.
- R3: A packed word holds four consecutive samples. The first sample is in bits 7:0, then 15:8, then 23:16, and the fourth sample is in bits 31:24.
- R4: Within a line, consecutive samples are exactly D+1 clock edges apart. This includes the gap from the fourth sample of one word to the first sample of the next.
- R5: The delay setting D is the 4-bit delay input clamped to the range 3..9. Inputs below 3 act as 3 and inputs above 9 act as 9.
- R6: D is captured on the edge where line sync is first seen low in the sync-wait state. Changing the delay input later in the line has no effect on the spacing until the next line.
- R7: The write strobe for a packed word is high for one cycle, on the cycle after the clock edge that takes the fourth sample.
- R8: On the edge where the first sample of a word would be taken, line sync is checked. If it is high, no sample is taken and the block enters the sync-wait state.
- R9: In the sync-wait state, while line sync is high, an all-zero word is written on the first edge and then every 3rd edge after it.
- R10: When line sync is first seen low in the sync-wait state at edge e, the first sample of the new line is taken at edge e+6. This is the 5-cycle alignment offset.
- R11: If the FIFO full input is high on the edge where a word (packed or zero) is produced, no strobe is issued and the word is dropped. The timing of all later samples is unchanged.
- R12: Line sync going high at the second, third or fourth sample of a word does not stop the capture. It appears as bit 7 of that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampler clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_i | input | 8 | Video port: line sync, frame sync, R1 R0 G1 G0 B1 B0 |
| delay_i | input | 4 | Per-pixel delay setting D, clamped to 3..9 |
| fifo_full_i | input | 1 | Downstream FIFO full flag |
| fifo_wr_o | output | 1 | One-cycle write strobe |
| fifo_data_o | output | 32 | Packed word, or zero during sync |

## Verification
The hardest situation to reach is line sync changing on or near an exact sample edge. The block reacts differently depending on whether that edge is a word boundary (R8) or a mid-word sample (R12). It also reacts differently depending on where within the 3-cycle zero-word cadence the sync ends, and that point sets the next line's phase. To cover these cases, the stimulus sends single-cycle sync pulses and sync windows of lengths that sweep through every residue of the pixel period and of the cadence. It does this while random FIFO-full pulses and mid-line delay changes are active. A behavioural model keeps queues of pending samples and predicts every output cycle, so each of those landing points is checked.

// File: rtl/ttl_samp_pkg.sv
package ttl_samp_pkg;

  typedef enum logic {
    ST_SYNC = 1'b0,
    ST_RUN  = 1'b1
  } samp_state_e;

  // Clamp a raw setting into [lo, hi].
  function automatic int span_fit(input int raw, input int lo, input int hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  // Larger of two counts, used to size shared counters.
  function automatic int count_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ttl_samp_timer.sv
module ttl_samp_timer #(
  parameter int CNT_W        = 4,
  parameter int ALIGN_OFFSET = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_align_i,
  input  logic             load_period_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_align_i)  cnt_q <= CNT_W'(ALIGN_OFFSET);
    else if (load_period_i) cnt_q <= period_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/ttl_samp_packer.sv
module ttl_samp_packer #(
  parameter int PIX_W        = 8,
  parameter int PIX_PER_WORD = 4,
  localparam int WORD_W      = PIX_W * PIX_PER_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_i,
  input  logic [PIX_W-1:0]  pix_i,
  output logic [WORD_W-1:0] word_o
);
  // Lanes hold earlier samples; lane 0 is the oldest.
  logic [PIX_W-1:0] lane_q [PIX_PER_WORD-1];

  for (genvar k = 0; k < PIX_PER_WORD - 1; k++) begin : g_lane
    if (k == PIX_PER_WORD - 2) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)          lane_q[k] <= '0;
        else if (shift_i) lane_q[k] <= pix_i;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)          lane_q[k] <= '0;
        else if (shift_i) lane_q[k] <= lane_q[k+1];
      end
    end
    assign word_o[k*PIX_W +: PIX_W] = lane_q[k];
  end

  // The newest sample goes straight into the top byte.
  assign word_o[WORD_W-1 -: PIX_W] = pix_i;
endmodule

// File: rtl/ttl_samp_ctrl.sv
module ttl_samp_ctrl
  import ttl_samp_pkg::*;
#(
  parameter int PIX_PER_WORD = 4,
  parameter int SYNC_PASS    = 3,
  parameter int IDX_W        = 2,
  parameter int ZC_W         = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hsync_i,
  input  logic tick_i,
  output logic in_sync_o,
  output logic line_start_o,
  output logic sample_fire_o,
  output logic word_done_o,
  output logic zero_write_o
);
  localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(PIX_PER_WORD - 1);
  localparam logic [ZC_W-1:0]  PASS_RELOAD = ZC_W'(SYNC_PASS - 1);

  samp_state_e      st_q, st_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [ZC_W-1:0]  zc_q, zc_n;

  always_comb begin
    st_n          = st_q;
    idx_n         = idx_q;
    zc_n          = zc_q;
    line_start_o  = 1'b0;
    sample_fire_o = 1'b0;
    word_done_o   = 1'b0;
    zero_write_o  = 1'b0;
    unique case (st_q)
      ST_SYNC: begin
        if (hsync_i) begin
          zero_write_o = (zc_q == '0);
          zc_n         = (zc_q == '0) ? PASS_RELOAD : zc_q - ZC_W'(1);
        end else begin
          line_start_o = 1'b1;
          st_n         = ST_RUN;
          idx_n        = '0;
        end
      end
      ST_RUN: begin
        if (tick_i) begin
          if (idx_q == '0 && hsync_i) begin
            st_n = ST_SYNC;
            zc_n = '0;
          end else begin
            sample_fire_o = 1'b1;
            word_done_o   = (idx_q == LAST_IDX);
            idx_n         = (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
          end
        end
      end
      default: st_n = ST_SYNC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_SYNC;
      idx_q <= '0;
      zc_q  <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      zc_q  <= zc_n;
    end
  end

  assign in_sync_o = (st_q == ST_SYNC);
endmodule

// File: rtl/ttl_video_sampler.sv
module ttl_video_sampler
  import ttl_samp_pkg::*;
#(
  parameter int PIX_W        = 8,
  parameter int PIX_PER_WORD = 4,
  parameter int DLY_W        = 4,
  parameter int DLY_MIN      = 3,
  parameter int DLY_MAX      = 9,
  parameter int ALIGN_OFFSET = 5,
  parameter int SYNC_PASS    = 3,
  parameter int HSYNC_BIT    = 7,
  localparam int WORD_W      = PIX_W * PIX_PER_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pins_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [WORD_W-1:0] fifo_data_o
);
  localparam int IDX_W = (PIX_PER_WORD > 1) ? $clog2(PIX_PER_WORD) : 1;
  localparam int CNT_W = $clog2(count_max(DLY_MAX, ALIGN_OFFSET) + 1);
  localparam int ZC_W  = $clog2(SYNC_PASS + 1);

  // Named internal events, visible to the bound checker.
  logic              hsync;
  logic              tick;
  logic              in_sync;
  logic              line_start;
  logic              sample_fire;
  logic              word_done;
  logic              zero_write;
  logic [CNT_W-1:0]  dly_q;
  logic [WORD_W-1:0] packed_word;

  assign hsync = pins_i[HSYNC_BIT];

  ttl_samp_ctrl #(
    .PIX_PER_WORD(PIX_PER_WORD),
    .SYNC_PASS   (SYNC_PASS),
    .IDX_W       (IDX_W),
    .ZC_W        (ZC_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .hsync_i      (hsync),
    .tick_i       (tick),
    .in_sync_o    (in_sync),
    .line_start_o (line_start),
    .sample_fire_o(sample_fire),
    .word_done_o  (word_done),
    .zero_write_o (zero_write)
  );

  ttl_samp_timer #(
    .CNT_W       (CNT_W),
    .ALIGN_OFFSET(ALIGN_OFFSET)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .load_align_i (line_start),
    .load_period_i(sample_fire),
    .period_i     (dly_q),
    .tick_o       (tick)
  );

  ttl_samp_packer #(
    .PIX_W       (PIX_W),
    .PIX_PER_WORD(PIX_PER_WORD)
  ) u_pack (
    .clk    (clk),
    .rst    (rst),
    .shift_i(sample_fire),
    .pix_i  (pins_i),
    .word_o (packed_word)
  );

  // Delay setting is captured only when a new line begins.
  always_ff @(posedge clk) begin
    if (rst)             dly_q <= CNT_W'(DLY_MIN);
    else if (line_start) dly_q <= CNT_W'(span_fit(int'(delay_i), DLY_MIN, DLY_MAX));
  end

  // Non-blocking write: a full FIFO drops the word, timing continues.
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr_o   <= 1'b0;
      fifo_data_o <= '0;
    end else begin
      fifo_wr_o <= (word_done | zero_write) & ~fifo_full_i;
      if (word_done)       fifo_data_o <= packed_word;
      else if (zero_write) fifo_data_o <= '0;
    end
  end
endmodule

// File: rtl/ttl_samp_checker.sv
module ttl_samp_checker #(
  parameter int CNT_W   = 4,
  parameter int WORD_W  = 32,
  parameter int DLY_MIN = 3,
  parameter int DLY_MAX = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_wr,
  input logic [WORD_W-1:0] fifo_data,
  input logic              fifo_full,
  input logic              in_sync,
  input logic              sample_fire,
  input logic [CNT_W-1:0]  dly_q
);
  // Edges since the previous sample within the current line.
  logic [7:0] gap_q;
  logic       have_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q       <= '0;
      have_prev_q <= 1'b0;
    end else begin
      if (sample_fire)       gap_q <= 8'd1;
      else if (gap_q != '1)  gap_q <= gap_q + 8'd1;
      if (sample_fire)       have_prev_q <= 1'b1;
      else if (in_sync)      have_prev_q <= 1'b0;
    end
  end

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |=> !fifo_wr);

  p_full_drop_r11: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_full) |-> !fifo_wr);

  p_zero_word_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr && $past(in_sync)) |-> (fifo_data == '0));

  p_delay_range_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(dly_q) >= DLY_MIN) && (int'(dly_q) <= DLY_MAX));

  p_delay_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!in_sync && !$past(in_sync)) |-> $stable(dly_q));

  p_pixel_period_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_fire && have_prev_q) |-> (int'(gap_q) == int'(dly_q) + 1));

  p_no_sample_in_sync_r8: assert property (@(posedge clk) disable iff (rst)
    in_sync |-> !sample_fire);
endmodule

bind ttl_video_sampler ttl_samp_checker #(
  .CNT_W  (CNT_W),
  .WORD_W (WORD_W),
  .DLY_MIN(DLY_MIN),
  .DLY_MAX(DLY_MAX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_wr    (fifo_wr_o),
  .fifo_data  (fifo_data_o),
  .fifo_full  (fifo_full_i),
  .in_sync    (in_sync),
  .sample_fire(sample_fire),
  .dly_q      (dly_q)
);

// File: tb/test_ttl_video_sampler.sv
module test_ttl_video_sampler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins_i = 8'h00;
  logic [3:0]  delay_i = 4'd3;
  logic        fifo_full_i = 1'b0;
  logic        fifo_wr_o;
  logic [31:0] fifo_data_o;

  int    checks = 0;
  int    errors = 0;
  int    cyc_n  = 0;
  bit    started = 0;
  bit    full_rand = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;  // 200 MHz

  ttl_video_sampler i_ttl_video_sampler (
    .clk(clk), .rst(rst), .pins_i(pins_i), .delay_i(delay_i),
    .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  pend[$];
  bit          m_waiting;
  int          m_pause, m_zgap, m_d;
  logic        m_we;
  logic [31:0] m_data;

  function automatic int fit_d(input int raw);
    int r;
    r = raw;
    if (r > 9) r = 9;
    if (r < 3) r = 3;
    return r;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_waiting = 1; m_zgap = 0; m_pause = 0; m_d = 3;
      m_we = 0; m_data = 0; pend.delete();
    end else begin
      m_we = 0;
      if (m_waiting) begin
        if (pins_i[7]) begin
          if (m_zgap == 0) begin
            m_we = !fifo_full_i; m_data = 0; m_zgap = 2;
          end else m_zgap--;
        end else begin
          m_waiting = 0; m_d = fit_d(int'(delay_i)); m_pause = 5; pend.delete();
        end
      end else if (m_pause > 0) begin
        m_pause--;
      end else if (pend.size() == 0 && pins_i[7]) begin
        m_waiting = 1; m_zgap = 0;
      end else begin
        pend.push_back(pins_i);
        m_pause = m_d;
        if (pend.size() == 4) begin
          m_we = !fifo_full_i;
          m_data = {pend[3], pend[2], pend[1], pend[0]};
          pend.delete();
        end
      end
    end
  end

  // ---------------- per-cycle comparison and watchdog ----------------
  always @(negedge clk) begin
    cyc_n++;
    if (cyc_n > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements): cycles %0d expected below 150000", cyc_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (started) begin
      checks++;
      if (fifo_wr_o !== m_we || fifo_data_o !== m_data) begin
        errors++;
        $display("FAIL %s: wr=%0b data=%h expected wr=%0b data=%h",
                 cur_req, fifo_wr_o, fifo_data_o, m_we, m_data);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic h, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pins_i = {h, 7'($urandom)};
      if (full_rand) fifo_full_i = ($urandom % 3) == 0;
    end
  endtask

  task automatic direct_check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    drive(1'b0, 4);
    @(negedge clk);
    direct_check("R1", {fifo_wr_o, fifo_data_o}, 33'h0);
    rst = 1'b0;
    @(negedge clk);
    direct_check("R1", {fifo_wr_o, fifo_data_o}, 33'h0);

    // R10 / R2 / R3 / R4: first line at minimum delay, counting pattern
    cur_req = "R10";
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      pins_i = {1'b0, 7'(i)};
    end
    cur_req = "R3";
    drive(1'b0, 150);

    // R8 / R9: sync windows of several lengths
    for (int w = 1; w <= 9; w++) begin
      cur_req = "R9";
      drive(1'b1, 10 + w);
      cur_req = "R8";
      drive(1'b0, 60 + 3 * w);
    end

    // R4 / R2: longest delay
    cur_req = "R4";
    delay_i = 4'd9;
    drive(1'b1, 6);
    drive(1'b0, 300);

    // R5: clamping below and above
    cur_req = "R5";
    delay_i = 4'd0;
    drive(1'b1, 5);
    drive(1'b0, 120);
    delay_i = 4'd15;
    drive(1'b1, 5);
    drive(1'b0, 200);

    // R6: change delay mid line
    cur_req = "R6";
    delay_i = 4'd4;
    drive(1'b1, 4);
    drive(1'b0, 50);
    delay_i = 4'd8;
    drive(1'b0, 100);
    delay_i = 4'd6;
    drive(1'b0, 80);

    // R12: single-cycle sync pulses at swept positions
    cur_req = "R12";
    delay_i = 4'd3;
    for (int i = 0; i < 60; i++) begin
      drive(1'b0, 5 + (i % 17));
      drive(1'b1, 1);
    end
    drive(1'b0, 40);

    // R11: random full flag, through lines and sync windows
    cur_req = "R11";
    full_rand = 1;
    for (int i = 0; i < 8; i++) begin
      delay_i = 4'(3 + i);
      drive(1'b1, 7 + i);
      drive(1'b0, 90);
    end
    full_rand = 0;
    fifo_full_i = 1'b0;

    // R7 / R2: mixed traffic with sync pulses, frame sync toggling randomly
    cur_req = "R7";
    for (int i = 0; i < 30; i++) begin
      delay_i = 4'($urandom % 12);
      drive(1'b1, 1 + (i % 7));
      drive(1'b0, 20 + (i % 13) * 7);
    end
    cur_req = "R2";
    drive(1'b0, 100);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule